// File: doc/BRIEF.md
# Precise Taint-Tracking Logic Cells

This block is a small library of logic cells in which every data bit travels with a one-bit trust label. A label of 1 marks a bit as untrusted (or secret); a label of 0 marks it as trusted (or public). Each cell produces its ordinary result and also a shadow label for that result. The shadow label is exact. It is 1 only when some choice of values on the untrusted input bits could change the output bit. It is not the plain OR of the input labels, because that OR marks too many bits as untrusted.

The cells are a two-input AND, a two-input OR, a 2:1 multiplexer with a shared select, and a D register. The register has a synchronous reset and a load enable, and both carry labels of their own. The register is built from two label-tracking multiplexers feeding a flop that stores data and label together. All data paths are `WIDTH` bits wide and are handled bit by bit; the select, enable and reset are single bits. The wrapper brings every cell out on its own ports so that each input and label combination can be driven directly.

The register is the only sequential part. It has no explicit state machine. Its stored data and label bits are its state, and on each clock edge one of three transitions moves them: reset, load or hold.

Top module: `taint_cells_top`

## Requirements
- R1: Data outputs follow ordinary logic: AND gives a&b, OR gives a|b, the multiplexer gives b when select is 1 and a when select is 0, and the register takes next = reset ? 0 : (enable ? d : q) on each rising clock edge.
- R2: The AND label bit is 1 exactly when some values on the untrusted inputs of that bit can change its output. In particular, a trusted 0 on either input gives a trusted output.
- R3: The OR label bit is 1 exactly when some values on the untrusted inputs of that bit can change its output. In particular, a trusted 1 on either input gives a trusted output.
- R4: With a trusted select, the multiplexer label equals the label of the selected data input only.
- R5: With an untrusted select, the multiplexer label bit is 1 when either data label bit is 1 or when the two data bits differ.
- R6: A trusted reset asserted at a clock edge leaves the register with data 0 and label 0.
- R7: A trusted load (trusted reset at 0, trusted enable at 1) stores d and its label d_t. A trusted load of trusted data therefore clears the label.
- R8: A trusted hold (reset and enable both 0 and trusted) keeps the stored data and label unchanged.
- R9: With a trusted reset at 0 and an untrusted enable, each stored label bit becomes 1 when d_t, the old label or (d xor old q) is 1.
- R10: With an untrusted reset, each stored label bit becomes 1 when the value the enable path would produce is untrusted or is nonzero.
- R11: A combinational cell never raises an output label bit when every input label bit it depends on is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| and_a | input | WIDTH | AND operand a |
| and_a_t | input | WIDTH | Label of and_a |
| and_b | input | WIDTH | AND operand b |
| and_b_t | input | WIDTH | Label of and_b |
| and_y | output | WIDTH | AND result |
| and_y_t | output | WIDTH | Label of and_y |
| or_a | input | WIDTH | OR operand a |
| or_a_t | input | WIDTH | Label of or_a |
| or_b | input | WIDTH | OR operand b |
| or_b_t | input | WIDTH | Label of or_b |
| or_y | output | WIDTH | OR result |
| or_y_t | output | WIDTH | Label of or_y |
| mux_sel | input | 1 | Multiplexer select (1 picks b) |
| mux_sel_t | input | 1 | Label of mux_sel |
| mux_a | input | WIDTH | Multiplexer input for select 0 |
| mux_a_t | input | WIDTH | Label of mux_a |
| mux_b | input | WIDTH | Multiplexer input for select 1 |
| mux_b_t | input | WIDTH | Label of mux_b |
| mux_y | output | WIDTH | Multiplexer result |
| mux_y_t | output | WIDTH | Label of mux_y |
| reg_rst | input | 1 | Register synchronous reset, active high |
| reg_rst_t | input | 1 | Label of reg_rst |
| reg_en | input | 1 | Register load enable |
| reg_en_t | input | 1 | Label of reg_en |
| reg_d | input | WIDTH | Register data in |
| reg_d_t | input | WIDTH | Label of reg_d |
| reg_q | output | WIDTH | Register stored data |
| reg_q_t | output | WIDTH | Register stored label |

## Verification
The bench works out each expected label from the definition of taint. For every bit it tries all values of the untrusted inputs and marks the output untrusted only if the result can take both values. It never evaluates a label formula. The sweep covers masking cases: a trusted 0 into the AND next to an untrusted 1, and a trusted 1 into the OR. A conservative OR of the labels would wrongly mark these outputs. It also covers an untrusted select over two equal trusted data bits. A design that ignored the data here would taint an output that cannot change. On the register it covers an untrusted reset over a trusted zero value, which must stay clean, and an untrusted enable over equal d and q, which must also stay clean. A design that dropped the old label or the reset taint would leave a label at 0 when the stored value could in fact differ.

// File: rtl/taint_pkg.sv
`timescale 1ns/1ps
package taint_pkg;
    typedef enum logic {
        LBL_TRUSTED   = 1'b0,
        LBL_UNTRUSTED = 1'b1
    } label_e;

    localparam int unsigned DEFAULT_WIDTH = 2;

    // Exact label of one 2:1 selection bit.
    function automatic logic sel_label(input logic s, input logic s_t,
                                       input logic a, input logic a_t,
                                       input logic b, input logic b_t);
        logic res;
        if (s_t) res = a_t | b_t | (a ^ b);
        else     res = s ? b_t : a_t;
        return res;
    endfunction
endpackage

// File: rtl/taint_and.sv
`timescale 1ns/1ps
module taint_and #(
    parameter int unsigned WIDTH = 2
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] a_t,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] b_t,
    output logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] y_t
);
    import taint_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            y[i]   = a[i] & b[i];
            y_t[i] = (a[i] & b_t[i]) | (b[i] & a_t[i]) | (a_t[i] & b_t[i]);
        end

        always_comb begin
            // R2: a trusted zero on either side masks the other side
            p_and_trusted_zero_r2: assert (!((!a[i] && a_t[i] == LBL_TRUSTED) ||
                                             (!b[i] && b_t[i] == LBL_TRUSTED)) ||
                                           y_t[i] == LBL_TRUSTED);
            // R11: no label from nothing
            p_and_no_overtaint_r11: assert (!(y_t[i] && !a_t[i] && !b_t[i]));
        end
    end
endmodule

// File: rtl/taint_or.sv
`timescale 1ns/1ps
module taint_or #(
    parameter int unsigned WIDTH = 2
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] a_t,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] b_t,
    output logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] y_t
);
    import taint_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            y[i]   = a[i] | b[i];
            y_t[i] = (~a[i] & b_t[i]) | (~b[i] & a_t[i]) | (a_t[i] & b_t[i]);
        end

        always_comb begin
            // R3: a trusted one on either side masks the other side
            p_or_trusted_one_r3: assert (!((a[i] && a_t[i] == LBL_TRUSTED) ||
                                           (b[i] && b_t[i] == LBL_TRUSTED)) ||
                                         y_t[i] == LBL_TRUSTED);
            // R11: no label from nothing
            p_or_no_overtaint_r11: assert (!(y_t[i] && !a_t[i] && !b_t[i]));
        end
    end
endmodule

// File: rtl/taint_mux.sv
`timescale 1ns/1ps
module taint_mux #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             s,
    input  logic             s_t,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] a_t,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] b_t,
    output logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] y_t
);
    import taint_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            y[i]   = s ? b[i] : a[i];
            y_t[i] = sel_label(s, s_t, a[i], a_t[i], b[i], b_t[i]);
        end

        always_comb begin
            // R4: trusted select passes only the chosen label
            p_mux_trusted_sel_r4: assert (s_t || (y_t[i] == (s ? b_t[i] : a_t[i])));
            // R5: untrusted select over equal trusted data stays clean
            p_mux_equal_data_r5: assert (!(s_t && a[i] == b[i] && !a_t[i] && !b_t[i]) ||
                                         y_t[i] == LBL_TRUSTED);
            // R11: no label from nothing
            p_mux_no_overtaint_r11: assert (!(y_t[i] && !s_t && !a_t[i] && !b_t[i]));
        end
    end
endmodule

// File: rtl/taint_reg.sv
`timescale 1ns/1ps
module taint_reg #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_t,
    input  logic             en,
    input  logic             en_t,
    input  logic [WIDTH-1:0] d,
    input  logic [WIDTH-1:0] d_t,
    output logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] q_t
);
    import taint_pkg::*;

    localparam logic [WIDTH-1:0] ZERO_VAL = '0;
    localparam logic [WIDTH-1:0] ZERO_LBL = {WIDTH{LBL_TRUSTED}};

    logic [WIDTH-1:0] load_v, load_t;
    logic [WIDTH-1:0] next_v, next_t;

    // enable path: hold q or take d
    taint_mux #(.WIDTH(WIDTH)) u_load (
        .s(en), .s_t(en_t),
        .a(q), .a_t(q_t),
        .b(d), .b_t(d_t),
        .y(load_v), .y_t(load_t)
    );

    // reset path: keep load result or force trusted zero
    taint_mux #(.WIDTH(WIDTH)) u_clear (
        .s(rst), .s_t(rst_t),
        .a(load_v), .a_t(load_t),
        .b(ZERO_VAL), .b_t(ZERO_LBL),
        .y(next_v), .y_t(next_t)
    );

    always_ff @(posedge clk) begin
        q   <= next_v;
        q_t <= next_t;
    end

    p_trusted_reset_r6: assert property (@(posedge clk) disable iff (rst_t)
        rst |=> (q == ZERO_VAL && q_t == ZERO_LBL));

    p_trusted_load_r7: assert property (@(posedge clk) disable iff (rst)
        (!rst_t && en && !en_t) |=> (q == $past(d) && q_t == $past(d_t)));

    p_trusted_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!rst_t && !en && !en_t) |=> ($stable(q) && $stable(q_t)));
endmodule

// File: rtl/taint_cells_top.sv
`timescale 1ns/1ps
module taint_cells_top #(
    parameter int unsigned WIDTH = taint_pkg::DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] and_a,
    input  logic [WIDTH-1:0] and_a_t,
    input  logic [WIDTH-1:0] and_b,
    input  logic [WIDTH-1:0] and_b_t,
    output logic [WIDTH-1:0] and_y,
    output logic [WIDTH-1:0] and_y_t,
    input  logic [WIDTH-1:0] or_a,
    input  logic [WIDTH-1:0] or_a_t,
    input  logic [WIDTH-1:0] or_b,
    input  logic [WIDTH-1:0] or_b_t,
    output logic [WIDTH-1:0] or_y,
    output logic [WIDTH-1:0] or_y_t,
    input  logic             mux_sel,
    input  logic             mux_sel_t,
    input  logic [WIDTH-1:0] mux_a,
    input  logic [WIDTH-1:0] mux_a_t,
    input  logic [WIDTH-1:0] mux_b,
    input  logic [WIDTH-1:0] mux_b_t,
    output logic [WIDTH-1:0] mux_y,
    output logic [WIDTH-1:0] mux_y_t,
    input  logic             reg_rst,
    input  logic             reg_rst_t,
    input  logic             reg_en,
    input  logic             reg_en_t,
    input  logic [WIDTH-1:0] reg_d,
    input  logic [WIDTH-1:0] reg_d_t,
    output logic [WIDTH-1:0] reg_q,
    output logic [WIDTH-1:0] reg_q_t
);
    taint_and #(.WIDTH(WIDTH)) u_and (
        .a(and_a), .a_t(and_a_t), .b(and_b), .b_t(and_b_t),
        .y(and_y), .y_t(and_y_t)
    );

    taint_or #(.WIDTH(WIDTH)) u_or (
        .a(or_a), .a_t(or_a_t), .b(or_b), .b_t(or_b_t),
        .y(or_y), .y_t(or_y_t)
    );

    taint_mux #(.WIDTH(WIDTH)) u_mux (
        .s(mux_sel), .s_t(mux_sel_t),
        .a(mux_a), .a_t(mux_a_t), .b(mux_b), .b_t(mux_b_t),
        .y(mux_y), .y_t(mux_y_t)
    );

    taint_reg #(.WIDTH(WIDTH)) u_reg (
        .clk(clk),
        .rst(reg_rst), .rst_t(reg_rst_t),
        .en(reg_en), .en_t(reg_en_t),
        .d(reg_d), .d_t(reg_d_t),
        .q(reg_q), .q_t(reg_q_t)
    );
endmodule

// File: tb/tb_taint_cells_top.sv
`timescale 1ns/1ps
module tb_taint_cells_top;
    localparam int W = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0] and_a, and_a_t, and_b, and_b_t, and_y, and_y_t;
    logic [W-1:0] or_a, or_a_t, or_b, or_b_t, or_y, or_y_t;
    logic         mux_sel, mux_sel_t;
    logic [W-1:0] mux_a, mux_a_t, mux_b, mux_b_t, mux_y, mux_y_t;
    logic         reg_rst, reg_rst_t, reg_en, reg_en_t;
    logic [W-1:0] reg_d, reg_d_t, reg_q, reg_q_t;

    int total = 0;
    int bad   = 0;

    taint_cells_top #(.WIDTH(W)) dut (
        .clk(clk),
        .and_a(and_a), .and_a_t(and_a_t), .and_b(and_b), .and_b_t(and_b_t),
        .and_y(and_y), .and_y_t(and_y_t),
        .or_a(or_a), .or_a_t(or_a_t), .or_b(or_b), .or_b_t(or_b_t),
        .or_y(or_y), .or_y_t(or_y_t),
        .mux_sel(mux_sel), .mux_sel_t(mux_sel_t),
        .mux_a(mux_a), .mux_a_t(mux_a_t), .mux_b(mux_b), .mux_b_t(mux_b_t),
        .mux_y(mux_y), .mux_y_t(mux_y_t),
        .reg_rst(reg_rst), .reg_rst_t(reg_rst_t),
        .reg_en(reg_en), .reg_en_t(reg_en_t),
        .reg_d(reg_d), .reg_d_t(reg_d_t),
        .reg_q(reg_q), .reg_q_t(reg_q_t)
    );

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // label by definition: can the untrusted inputs move the output?
    // op 0 = and, 1 = or, 2 = select (s,a,b)
    function automatic logic can_move(input int op,
                                      input logic x, input logic xt,
                                      input logic y, input logic yt,
                                      input logic z, input logic zt);
        logic seen0 = 1'b0;
        logic seen1 = 1'b0;
        for (int vx = 0; vx < 2; vx++) begin
            for (int vy = 0; vy < 2; vy++) begin
                for (int vz = 0; vz < 2; vz++) begin
                    logic ux, uy, uz, r;
                    ux = xt ? logic'(vx) : x;
                    uy = yt ? logic'(vy) : y;
                    uz = zt ? logic'(vz) : z;
                    case (op)
                        0: r = ux & uy;
                        1: r = ux | uy;
                        default: r = ux ? uz : uy;
                    endcase
                    if (r) seen1 = 1'b1; else seen0 = 1'b1;
                end
            end
        end
        return seen0 & seen1;
    endfunction

    function automatic logic reg_move(input logic r, input logic rt,
                                      input logic e, input logic et,
                                      input logic dv, input logic dt,
                                      input logic qv, input logic qt);
        logic seen0 = 1'b0;
        logic seen1 = 1'b0;
        for (int k = 0; k < 16; k++) begin
            logic ur, ue, ud, uq, nx;
            ur = rt ? logic'(k[0]) : r;
            ue = et ? logic'(k[1]) : e;
            ud = dt ? logic'(k[2]) : dv;
            uq = qt ? logic'(k[3]) : qv;
            nx = ur ? 1'b0 : (ue ? ud : uq);
            if (nx) seen1 = 1'b1; else seen0 = 1'b1;
        end
        return seen0 & seen1;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        #1ms;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        and_a = '0; and_a_t = '0; and_b = '0; and_b_t = '0;
        or_a = '0; or_a_t = '0; or_b = '0; or_b_t = '0;
        mux_sel = 1'b0; mux_sel_t = 1'b0;
        mux_a = '0; mux_a_t = '0; mux_b = '0; mux_b_t = '0;
        reg_rst = 1'b1; reg_rst_t = 1'b0; reg_en = 1'b0; reg_en_t = 1'b0;
        reg_d = '1; reg_d_t = '1;
        @(negedge clk);
        tick();
        check("R6 reset data", reg_q, '0);
        check("R6 reset label", reg_q_t, '0);

        // AND and OR: every operand and label pattern
        for (int v = 0; v < 256; v++) begin
            logic [W-1:0] ea, et, oa, ot;
            and_a = v[1:0]; and_a_t = v[3:2]; and_b = v[5:4]; and_b_t = v[7:6];
            or_a  = v[1:0]; or_a_t  = v[3:2]; or_b  = v[5:4]; or_b_t  = v[7:6];
            #1;
            for (int i = 0; i < W; i++) begin
                ea[i] = v[i] & v[4+i];
                oa[i] = v[i] | v[4+i];
                et[i] = can_move(0, v[i], v[2+i], v[4+i], v[6+i], 1'b0, 1'b0);
                ot[i] = can_move(1, v[i], v[2+i], v[4+i], v[6+i], 1'b0, 1'b0);
            end
            check("R1 and data", and_y, ea);
            check((v[7:6] == 2'b00 && v[3:2] == 2'b00) ? "R11 and label" : "R2 and label",
                  and_y_t, et);
            check("R1 or data", or_y, oa);
            check((v[7:6] == 2'b00 && v[3:2] == 2'b00) ? "R11 or label" : "R3 or label",
                  or_y_t, ot);
        end

        // multiplexer: every select, data and label pattern
        for (int v = 0; v < 1024; v++) begin
            logic [W-1:0] ey, et;
            mux_a = v[1:0]; mux_a_t = v[3:2]; mux_b = v[5:4]; mux_b_t = v[7:6];
            mux_sel = v[8]; mux_sel_t = v[9];
            #1;
            for (int i = 0; i < W; i++) begin
                ey[i] = v[8] ? v[4+i] : v[i];
                et[i] = can_move(2, v[8], v[9], v[i], v[2+i], v[4+i], v[6+i]);
            end
            check("R1 mux data", mux_y, ey);
            check(v[9] ? "R5 mux label" : "R4 mux label", mux_y_t, et);
        end

        // register: preload with a trusted load, then apply a control pattern
        for (int v = 0; v < 4096; v++) begin
            logic [W-1:0] pq, pt, dv, dt, eq, et;
            logic r, rt, e, ent;
            string tag;
            pq = v[1:0]; pt = v[3:2]; dv = v[5:4]; dt = v[7:6];
            r = v[8]; rt = v[9]; e = v[10]; ent = v[11];
            reg_rst = 1'b0; reg_rst_t = 1'b0; reg_en = 1'b1; reg_en_t = 1'b0;
            reg_d = pq; reg_d_t = pt;
            tick();
            check("R7 preload", {reg_q, reg_q_t}, {pq, pt});
            reg_rst = r; reg_rst_t = rt; reg_en = e; reg_en_t = ent;
            reg_d = dv; reg_d_t = dt;
            tick();
            for (int i = 0; i < W; i++) begin
                eq[i] = r ? 1'b0 : (e ? dv[i] : pq[i]);
                et[i] = reg_move(r, rt, e, ent, dv[i], dt[i], pq[i], pt[i]);
            end
            if (rt)       tag = "R10 untrusted reset";
            else if (r)   tag = "R6 trusted reset";
            else if (ent) tag = "R9 untrusted enable";
            else if (e)   tag = "R7 trusted load";
            else          tag = "R8 trusted hold";
            check({"R1 ", tag, " data"}, reg_q, eq);
            check({tag, " label"}, reg_q_t, et);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule